// File: doc/BRIEF.md
# Legacy Banked Memory Paging Unit

This block watches CPU I/O writes and keeps three paging registers: a main paging port, a bank extension port and an auxiliary paging port. From them it builds the physical 16K bank number for each of the four 16K slots of a 64KB CPU address space. It also produces a 2-bit ROM select, a screen-bank flag and a per-slot flag that marks a slot as ROM or RAM.

In normal mode the bottom slot shows a ROM, the two middle slots hold fixed banks, and the top slot holds a 7-bit RAM bank. That bank number is formed from four upper bits in the extension port and three lower bits in the main port. In the all-RAM special mode a 2-bit configuration picks one of four fixed bank layouts for all four slots.

A lock bit in the main port freezes all three registers. An external override input lets writes through while the lock is set. A register takes a write on the clock edge where `io_wr` is high, and the outputs show the new value from the following cycle.

Top module: `mem_pager`

## Requirements
- R1: After reset all three registers are zero. The outputs are then: slot 0 flagged ROM with bank 0, slot 1 bank 5, slot 2 bank 2, slot 3 bank 0, `rom_sel` 00, `screen_alt` 0 and `lock_active` 0.
- R2: The main port is addressed when A15:A14 = 01 and A1:A0 = 01. It stores the following data bits:
  - bits 2:0 are the low bank bits for the top slot;
  - bit 3 drives `screen_alt` (1 selects bank 7 as the screen, 0 selects bank 5);
  - bit 4 is `rom_sel[0]`;
  - bit 5 is the lock, shown on `lock_active`.
- R3: The extension port is addressed when A15:A13 = 110 and A1:A0 = 01. Its data bits 3:0 are the upper bank bits. In normal mode slot 3 shows extension*8 + main bank bits, covering banks 0 through 127.
- R4: The auxiliary port is addressed when A15:A14 = 00 and A1:A0 = 01. Its data bit 2 is `rom_sel[1]`, so `rom_sel` = {aux bit 2, main bit 4}.
- R5: In normal mode (aux bit 0 = 0), `slot_rom` = 0001 and slot 0 reports bank 0. Slot 1 is bank 5 and slot 2 is bank 2.
- R6: When aux bit 0 = 1 (special mode), aux bits 2:1 select the banks for slots 0 to 3 as follows:
  - 00 gives 0,1,2,3;
  - 01 gives 4,5,6,7;
  - 10 gives 5,5,6,3;
  - 11 gives 4,7,6,3.
- R7: In special mode all four slots are flagged RAM (`slot_rom` = 0000).
- R8: When special mode is cleared, slots 1 and 2 return to banks 5 and 2. Slots 0 and 3 follow the stored port values again.
- R9: While the lock is set and `lock_override` is 0, writes to any of the three ports leave every output unchanged.
- R10: While `lock_override` is 1, writes to all three ports take effect even when locked. This includes clearing the lock itself.
- R11: A write whose address matches none of the three port patterns changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | CPU I/O address |
| io_data | input | 8 | CPU I/O write data |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| lock_override | input | 1 | Lets writes through while the lock is set |
| bank_s0 | output | 7 | Bank for 0x0000-0x3FFF |
| bank_s1 | output | 7 | Bank for 0x4000-0x7FFF |
| bank_s2 | output | 7 | Bank for 0x8000-0xBFFF |
| bank_s3 | output | 7 | Bank for 0xC000-0xFFFF |
| slot_rom | output | 4 | Per-slot ROM flag, bit n for slot n |
| rom_sel | output | 2 | ROM image number 0 to 3 |
| screen_alt | output | 1 | 1 selects bank 7 as the screen, 0 selects bank 5 |
| lock_active | output | 1 | Current lock bit |

## Verification
The assertions assume that `io_wr` is a single-cycle strobe and that `io_addr`, `io_data` and `lock_override` are stable around the clock edge that samples them. The bench drives all inputs on the falling edge and lowers `io_wr` one cycle later, which keeps every write inside those assumptions. The bench changes `lock_override` only between writes, so each lock-related property sees a steady override level during the cycle it checks.

// File: rtl/pager_pkg.sv
package pager_pkg;

  typedef enum logic [1:0] {
    PSEL_NONE = 2'd0,
    PSEL_MAIN = 2'd1,
    PSEL_EXT  = 2'd2,
    PSEL_AUX  = 2'd3
  } psel_e;

  localparam int SPECIAL_W = 3;

  // Which paging register an I/O address targets.
  function automatic psel_e classify(input logic [15:0] a);
    if (a[1:0] != 2'b01)       return PSEL_NONE;
    if (a[15:14] == 2'b01)     return PSEL_MAIN;
    if (a[15:13] == 3'b110)    return PSEL_EXT;
    if (a[15:14] == 2'b00)     return PSEL_AUX;
    return PSEL_NONE;
  endfunction

  // All-RAM layout: bank for one slot under one configuration.
  function automatic logic [SPECIAL_W-1:0] special_bank(input logic [1:0] cfg,
                                                        input logic [1:0] slot);
    logic [4*SPECIAL_W-1:0] row;
    case (cfg)
      2'b00:   row = {3'd3, 3'd2, 3'd1, 3'd0};
      2'b01:   row = {3'd7, 3'd6, 3'd5, 3'd4};
      2'b10:   row = {3'd3, 3'd6, 3'd5, 3'd5};
      default: row = {3'd3, 3'd6, 3'd7, 3'd4};
    endcase
    return row[int'(slot)*SPECIAL_W +: SPECIAL_W];
  endfunction

  // Top-slot bank: upper bits from extension, lower bits from main port.
  function automatic logic [10:0] join_bank(input logic [7:0] hi, input logic [2:0] lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/pager_decode.sv
module pager_decode
  import pager_pkg::*;
(
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  output logic        main_wr,
  output logic        ext_wr,
  output logic        aux_wr,
  output logic        stray_wr
);
  psel_e sel;
  wire   addr_unused = ^io_addr;

  always_comb begin
    sel      = classify(io_addr);
    main_wr  = io_wr && (sel == PSEL_MAIN);
    ext_wr   = io_wr && (sel == PSEL_EXT);
    aux_wr   = io_wr && (sel == PSEL_AUX);
    stray_wr = io_wr && (sel == PSEL_NONE);
  end
endmodule

// File: rtl/pager_regs.sv
module pager_regs #(
  parameter int LO_W = 3,
  parameter int HI_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            main_wr,
  input  logic            ext_wr,
  input  logic            aux_wr,
  input  logic            lock_override,
  input  logic [7:0]      io_data,
  output logic [LO_W-1:0] main_bank,
  output logic            screen_alt,
  output logic            rom_lo,
  output logic            lock_on,
  output logic [HI_W-1:0] ext_bank,
  output logic [1:0]      aux_cfg,
  output logic            special_on,
  output logic            rom_hi
);
  logic [2:0] aux_q;
  logic       write_gate;
  wire        data_unused = ^io_data;

  assign write_gate = !lock_on || lock_override;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_bank  <= '0;
      screen_alt <= 1'b0;
      rom_lo     <= 1'b0;
      lock_on    <= 1'b0;
      ext_bank   <= '0;
      aux_q      <= '0;
    end else if (write_gate) begin
      if (main_wr) begin
        main_bank  <= io_data[LO_W-1:0];
        screen_alt <= io_data[3];
        rom_lo     <= io_data[4];
        lock_on    <= io_data[5];
      end
      if (ext_wr) ext_bank <= io_data[HI_W-1:0];
      if (aux_wr) aux_q    <= io_data[2:0];
    end
  end

  assign aux_cfg    = aux_q[2:1];
  assign rom_hi     = aux_q[2];
  assign special_on = aux_q[0];

  // R9: lock without override freezes every register
  a_r9_lock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_on && !lock_override) |=>
      ($stable(main_bank) && $stable(ext_bank) && $stable(aux_q) &&
       $stable(screen_alt) && $stable(rom_lo) && lock_on));

  // R10: override lets an extension write land while locked
  a_r10_override_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_wr && lock_on && lock_override) |=> ext_bank == $past(io_data[HI_W-1:0]));

  // R2: an accepted main-port write lands in the next cycle
  a_r2_main_load: assert property (@(posedge clk) disable iff (!rst_n)
    (main_wr && write_gate) |=>
      ({lock_on, rom_lo, screen_alt, main_bank} ==
       {$past(io_data[5:3]), $past(io_data[LO_W-1:0])}));
endmodule

// File: rtl/pager_slots.sv
module pager_slots
  import pager_pkg::*;
#(
  parameter int LO_W = 3,
  parameter int HI_W = 4,
  localparam int BANK_W = LO_W + HI_W,
  localparam int SLOTS  = 4
) (
  input  logic                        special_on,
  input  logic [1:0]                  aux_cfg,
  input  logic [LO_W-1:0]             main_bank,
  input  logic [HI_W-1:0]             ext_bank,
  output logic [SLOTS-1:0][BANK_W-1:0] slot_bank,
  output logic [SLOTS-1:0]            slot_rom
);
  localparam logic [BANK_W-1:0] FIXED_S1 = BANK_W'(5);
  localparam logic [BANK_W-1:0] FIXED_S2 = BANK_W'(2);

  logic [10:0] joined;
  assign joined = join_bank(8'(ext_bank), 3'(main_bank));

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_comb begin
      if (special_on) begin
        slot_bank[s] = BANK_W'(special_bank(aux_cfg, 2'(s)));
        slot_rom[s]  = 1'b0;
      end else begin
        slot_rom[s] = (s == 0);
        if (s == 0)      slot_bank[s] = '0;
        else if (s == 1) slot_bank[s] = FIXED_S1;
        else if (s == 2) slot_bank[s] = FIXED_S2;
        else             slot_bank[s] = joined[BANK_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mem_pager.sv
module mem_pager #(
  parameter int LO_W = 3,
  parameter int HI_W = 4,
  localparam int BANK_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       io_addr,
  input  logic [7:0]        io_data,
  input  logic              io_wr,
  input  logic              lock_override,
  output logic [BANK_W-1:0] bank_s0,
  output logic [BANK_W-1:0] bank_s1,
  output logic [BANK_W-1:0] bank_s2,
  output logic [BANK_W-1:0] bank_s3,
  output logic [3:0]        slot_rom,
  output logic [1:0]        rom_sel,
  output logic              screen_alt,
  output logic              lock_active
);
  logic                    main_wr, ext_wr, aux_wr, stray_wr;
  logic [LO_W-1:0]         main_bank;
  logic [HI_W-1:0]         ext_bank;
  logic [1:0]              aux_cfg;
  logic                    special_on, rom_lo, rom_hi;
  logic [3:0][BANK_W-1:0]  slot_bank;

  pager_decode u_dec (
    .io_addr(io_addr), .io_wr(io_wr),
    .main_wr(main_wr), .ext_wr(ext_wr), .aux_wr(aux_wr), .stray_wr(stray_wr)
  );

  pager_regs #(.LO_W(LO_W), .HI_W(HI_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .main_wr(main_wr), .ext_wr(ext_wr), .aux_wr(aux_wr),
    .lock_override(lock_override), .io_data(io_data),
    .main_bank(main_bank), .screen_alt(screen_alt), .rom_lo(rom_lo),
    .lock_on(lock_active), .ext_bank(ext_bank), .aux_cfg(aux_cfg),
    .special_on(special_on), .rom_hi(rom_hi)
  );

  pager_slots #(.LO_W(LO_W), .HI_W(HI_W)) u_slots (
    .special_on(special_on), .aux_cfg(aux_cfg),
    .main_bank(main_bank), .ext_bank(ext_bank),
    .slot_bank(slot_bank), .slot_rom(slot_rom)
  );

  assign bank_s0 = slot_bank[0];
  assign bank_s1 = slot_bank[1];
  assign bank_s2 = slot_bank[2];
  assign bank_s3 = slot_bank[3];
  assign rom_sel = {rom_hi, rom_lo};

  // R7: special mode never flags a ROM slot
  a_r7_all_ram: assert property (@(posedge clk) disable iff (!rst_n)
    special_on |-> slot_rom == 4'b0000);

  // R5: normal mode keeps the fixed middle banks and a ROM bottom slot
  a_r5_normal_layout: assert property (@(posedge clk) disable iff (!rst_n)
    !special_on |-> (bank_s1 == BANK_W'(5) && bank_s2 == BANK_W'(2) && slot_rom == 4'b0001));

  // R8: leaving special mode restores the middle slots at once
  a_r8_exit_restore: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(special_on) |-> (bank_s1 == BANK_W'(5) && bank_s2 == BANK_W'(2)));

  // R6: every special layout stays within banks 0..7
  a_r6_special_range: assert property (@(posedge clk) disable iff (!rst_n)
    special_on |-> (bank_s0 < BANK_W'(8) && bank_s3 < BANK_W'(8)));

  // R11: a write to no paging port changes nothing
  a_r11_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    stray_wr |=> ($stable(bank_s0) && $stable(bank_s3) && $stable(rom_sel) &&
                  $stable(screen_alt) && $stable(lock_active) && $stable(slot_rom)));
endmodule

// File: tb/mem_pager_test.sv
`timescale 1ns/1ps
module mem_pager_test;
  localparam real CYC = 8.0;

  typedef struct {
    logic [35:0] v;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_data = '0;
  logic        io_wr = 1'b0;
  logic        lock_override = 1'b0;
  logic [6:0]  bank_s0, bank_s1, bank_s2, bank_s3;
  logic [3:0]  slot_rom;
  logic [1:0]  rom_sel;
  logic        screen_alt, lock_active;

  int total = 0;
  int bad = 0;
  bit done = 0;
  item_t q[$];

  // bench model of the three registers
  logic [7:0] m_main = 0, m_ext = 0, m_aux = 0;
  int layout [4][4] = '{'{0,1,2,3}, '{4,5,6,7}, '{5,5,6,3}, '{4,7,6,3}};

  always #(CYC/2) clk = ~clk;

  mem_pager uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_data(io_data), .io_wr(io_wr),
    .lock_override(lock_override), .bank_s0(bank_s0), .bank_s1(bank_s1),
    .bank_s2(bank_s2), .bank_s3(bank_s3), .slot_rom(slot_rom), .rom_sel(rom_sel),
    .screen_alt(screen_alt), .lock_active(lock_active)
  );

  function automatic logic [35:0] model_vec();
    int b[4];
    logic [3:0] rf;
    if (m_aux[0]) begin
      for (int s = 0; s < 4; s++) b[s] = layout[m_aux[2:1]][s];
      rf = 4'b0000;
    end else begin
      b[0] = 0; b[1] = 5; b[2] = 2;
      b[3] = int'(m_ext[3:0]) * 8 + int'(m_main[2:0]);
      rf = 4'b0001;
    end
    return {7'(b[0]), 7'(b[1]), 7'(b[2]), 7'(b[3]), rf,
            m_aux[2], m_main[4], m_main[3], m_main[5]};
  endfunction

  task automatic push(input string tag);
    item_t it;
    it.v = model_vec();
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    io_addr = a; io_data = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    if (!m_main[5] || lock_override) begin
      if (a[1:0] == 2'b01) begin
        if (a[15:14] == 2'b01)       m_main = d;
        else if (a[15:13] == 3'b110) m_ext = d;
        else if (a[15:14] == 2'b00)  m_aux = d;
      end
    end
    push(tag);
  endtask

  // monitor: compare after the falling edge on which each item is queued
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [35:0] got;
        it = q.pop_front();
        got = {bank_s0, bank_s1, bank_s2, bank_s3, slot_rom, rom_sel, screen_alt, lock_active};
        total++;
        if (got !== it.v) begin
          bad++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.v);
        end
      end
    end
  end

  initial begin
    #(CYC * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push("R1 reset state");
    // R2: main port fields
    wr(16'h7FFD, 8'h1D, "R2 main fields");
    // R3: composed top bank extremes
    wr(16'hDFFD, 8'h0F, "R3 ext upper");
    wr(16'h7FFD, 8'h07, "R3 bank 127");
    wr(16'hDFFD, 8'h00, "R3 ext clear");
    wr(16'h7FFD, 8'h00, "R3 bank 0");
    wr(16'hDFFD, 8'h0A, "R3 mid bank");
    // R4: high ROM bit
    wr(16'h1FFD, 8'h04, "R4 rom hi");
    wr(16'h7FFD, 8'h10, "R4 rom 3");
    // R6 / R7: four special layouts
    wr(16'h1FFD, 8'h01, "R6 layout 00");
    wr(16'h1FFD, 8'h03, "R6 layout 01");
    wr(16'h1FFD, 8'h05, "R7 layout 10");
    wr(16'h1FFD, 8'h07, "R7 layout 11");
    // R8: leave special mode
    wr(16'h1FFD, 8'h00, "R8 restore");
    // R5: normal layout with moved top bank
    wr(16'h7FFD, 8'h03, "R5 normal");
    // R11: stray addresses
    wr(16'h7FFC, 8'h07, "R11 A0 low");
    wr(16'hFFFD, 8'h3F, "R11 high addr");
    wr(16'hBFFD, 8'h0F, "R11 other addr");
    // R9: lock freezes all ports
    wr(16'h7FFD, 8'h26, "R9 set lock");
    wr(16'h7FFD, 8'h01, "R9 main blocked");
    wr(16'hDFFD, 8'h05, "R9 ext blocked");
    wr(16'h1FFD, 8'h01, "R9 aux blocked");
    // R10: override re-enables writes
    @(negedge clk); lock_override = 1'b1;
    wr(16'hDFFD, 8'h03, "R10 ext via override");
    wr(16'h1FFD, 8'h03, "R10 aux via override");
    wr(16'h7FFD, 8'h05, "R10 unlock");
    @(negedge clk); lock_override = 1'b0;
    wr(16'h1FFD, 8'h00, "R10 after unlock");
    wr(16'h7FFD, 8'h02, "R10 normal write");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule